// File: doc/BRIEF.md
# SMBus Block-Transfer Data Buffer

This block holds the data for SMBus block reads and block writes. It sits between a register front-end and a bus engine. Software reaches it through a block-data byte port, a status-write strobe and a small auxiliary-control field. The bus engine fills the buffer for reads and drains it for writes through its own ports. The front-end asks for a transaction with `start`. When the transaction is due to run, it pulses `exec` and supplies the direction, the byte count (the value held in its data0 register) and the length the device returned.

There are two modes. In buffered mode, software streams up to 32 bytes through the block-data port, and an index steps by one on each access. In byte-by-byte mode, one byte at a time is exchanged through a holding register. A "byte done" flag hands over each byte, and software acknowledges it by writing the status register. On a read, a last-byte flag from the control register ends the transfer.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset, `busy`, `done`, `byte_done` and `dev_err` are 0, `aux_q` is 0, the index is 0 and `blk_rdata` reads 0.
- R2: A write on the auxiliary port keeps only bits [1:0]. Bit 1 selects buffered mode and bit 0 is the PEC-append flag. Both are returned on `aux_q`.
- R3: In buffered mode, each `blk_wr` stores `blk_wdata` at the index and then increments it. A block-data access made while the index is 32 or more first wraps the index to 0.
- R4: A buffered write `exec` with the index equal to `count` pulses `send_req` for one cycle, sets `done` and clears `busy`. Otherwise it sets `dev_err`, sends nothing and resets the index to 0.
- R5: A read `exec` pulses `len_we` with `len_q` = `rd_len`. In buffered mode it also sets `done`, and each `blk_rd` steps to the next byte shown on `blk_rdata`. When the index reaches `count`, the transfer ends and the index returns to 0.
- R6: A byte-mode read `exec` puts buffer byte 0 on `blk_rdata` and sets both `busy` and `byte_done`.
- R7: In a byte-mode read, each status write advances the index. Without `last_byte` it loads the next byte and sets `byte_done`. With `last_byte` it loads that byte, sets `done` and clears `busy`.
- R8: A byte-mode write `exec` stores the holding byte as buffer byte 0 and sets `busy` and `byte_done`. Each status write then advances the index. Below `count` it stores the holding byte at the new index and sets `byte_done`. At `count` it pulses `send_req`, sets `done` and clears `busy`.
- R9: `start` sets `busy`. If an operation is still unfinished, `start` also resets the index to 0 and marks that operation finished.
- R10: An `exec` while `dev_err` is set only clears `busy`. It neither sends nor reports a length.
- R11: A status write clears `done` (bit 0), `byte_done` (bit 1) and `dev_err` (bit 2) where `sts_wdata` has a 1. A flag set by the same write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| aux_wr | input | 1 | Auxiliary-control write strobe |
| aux_wdata | input | 8 | Auxiliary-control write data |
| aux_q | output | 2 | Stored mode bits (bit 1 buffered, bit 0 PEC) |
| start | input | 1 | Transaction start request |
| exec | input | 1 | Run the pending transaction |
| is_read | input | 1 | Direction of the transaction (1 = read) |
| count | input | 8 | Byte count from the front-end data0 register |
| last_byte | input | 1 | Last-byte flag from the control register |
| rd_len | input | 8 | Length returned by the device on a read |
| blk_wr | input | 1 | Block-data write strobe |
| blk_wdata | input | 8 | Block-data write byte |
| blk_rd | input | 1 | Block-data read strobe (side effect) |
| blk_rdata | output | 8 | Block-data read value |
| sts_wr | input | 1 | Status-register write strobe (acknowledge) |
| sts_wdata | input | 3 | Clear mask: done, byte_done, dev_err |
| busy | output | 1 | Host busy |
| done | output | 1 | Transfer complete |
| byte_done | output | 1 | Byte handed over |
| dev_err | output | 1 | Device error |
| len_we | output | 1 | One-cycle pulse: load `len_q` into data0 |
| len_q | output | 8 | Returned read length |
| send_req | output | 1 | One-cycle pulse: engine sends `count` bytes |
| eng_we | input | 1 | Engine buffer write enable |
| eng_waddr | input | 5 | Engine buffer write address |
| eng_wdata | input | 8 | Engine buffer write byte |
| eng_raddr | input | 5 | Engine buffer read address |
| eng_rdata | output | 8 | Engine buffer read byte |

## Verification
The hardest states to reach are the index wrap and a `start` that arrives while a buffered read is still unfinished. A wrap needs 32 block-data writes with no transfer in between. The stale index only shows when a read is left partly drained. The bench first fills the whole buffer after a failed write, so that byte 0 is overwritten only by the wrapped access. It then runs a buffered read, consumes one byte and issues `start`, and checks that `blk_rdata` returns to byte 0. Byte-mode sequences are driven one acknowledge at a time. Each buffer byte is read back through the engine port.

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int IW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     aux_wr,
  input  logic [DW-1:0]            aux_wdata,
  output logic [1:0]               aux_q,
  input  logic                     start,
  input  logic                     exec,
  input  logic                     is_read,
  input  logic [IW-1:0]            count,
  input  logic                     last_byte,
  input  logic [IW-1:0]            rd_len,
  input  logic                     blk_wr,
  input  logic [DW-1:0]            blk_wdata,
  input  logic                     blk_rd,
  output logic [DW-1:0]            blk_rdata,
  input  logic                     sts_wr,
  input  logic [2:0]               sts_wdata,
  output logic                     busy,
  output logic                     done,
  output logic                     byte_done,
  output logic                     dev_err,
  output logic                     len_we,
  output logic [IW-1:0]            len_q,
  output logic                     send_req,
  input  logic                     eng_we,
  input  logic [$clog2(DEPTH)-1:0] eng_waddr,
  input  logic [DW-1:0]            eng_wdata,
  input  logic [$clog2(DEPTH)-1:0] eng_raddr,
  output logic [DW-1:0]            eng_rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx, idx_eff, idx_nx, idx_inc;
  logic [DW-1:0] hold;
  logic          fin;
  logic          buffered, hs_active, run;
  logic          hw_we;
  logic [AW-1:0] hw_addr;
  logic [DW-1:0] hw_data;

  assign buffered  = aux_q[1];
  assign idx_eff   = (idx >= IW'(DEPTH)) ? '0 : idx;
  assign idx_inc   = idx_eff + IW'(1);
  assign idx_nx    = idx + IW'(1);
  assign hs_active = !fin && !buffered;
  assign run       = exec && busy;

  assign blk_rdata = buffered ? mem[idx_eff[AW-1:0]] : hold;
  assign eng_rdata = mem[eng_raddr];

  always_comb begin
    hw_we   = 1'b0;
    hw_addr = '0;
    hw_data = hold;
    if (start) begin
      hw_we = 1'b0;
    end else if (run) begin
      hw_we = !dev_err && !is_read && !buffered;
    end else if (sts_wr) begin
      hw_we   = hs_active && !is_read && (idx_nx != count);
      hw_addr = idx_nx[AW-1:0];
    end else if (blk_wr && buffered) begin
      hw_we   = 1'b1;
      hw_addr = idx_eff[AW-1:0];
      hw_data = blk_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (eng_we) mem[eng_waddr] <= eng_wdata;
    if (hw_we)  mem[hw_addr]   <= hw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q     <= '0;
      idx       <= '0;
      hold      <= '0;
      fin       <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      byte_done <= 1'b0;
      dev_err   <= 1'b0;
      len_we    <= 1'b0;
      len_q     <= '0;
      send_req  <= 1'b0;
    end else begin
      len_we   <= 1'b0;
      send_req <= 1'b0;
      if (aux_wr) aux_q <= aux_wdata[1:0];

      if (start) begin
        busy <= 1'b1;
        if (!fin) begin
          idx <= '0;
          fin <= 1'b1;
        end
      end else if (run) begin
        busy <= 1'b0;
        if (!dev_err) begin
          if (is_read) begin
            len_we <= 1'b1;
            len_q  <= rd_len;
            idx    <= '0;
            fin    <= 1'b0;
            if (buffered) begin
              done <= 1'b1;
            end else begin
              hold      <= mem[0];
              busy      <= 1'b1;
              byte_done <= 1'b1;
            end
          end else if (buffered) begin
            idx <= '0;
            if (idx != count) begin
              dev_err <= 1'b1;
            end else begin
              send_req <= 1'b1;
              fin      <= 1'b1;
              done     <= 1'b1;
            end
          end else begin
            idx       <= '0;
            fin       <= 1'b0;
            busy      <= 1'b1;
            byte_done <= 1'b1;
          end
        end
      end else if (sts_wr) begin
        if (sts_wdata[0]) done      <= 1'b0;
        if (sts_wdata[1]) byte_done <= 1'b0;
        if (sts_wdata[2]) dev_err   <= 1'b0;
        if (hs_active) begin
          idx <= idx_nx;
          if (!is_read) begin
            if (idx_nx == count) begin
              send_req <= 1'b1;
              fin      <= 1'b1;
              done     <= 1'b1;
              busy     <= 1'b0;
            end else begin
              byte_done <= 1'b1;
            end
          end else if (last_byte) begin
            hold <= mem[idx_nx[AW-1:0]];
            idx  <= '0;
            fin  <= 1'b1;
            done <= 1'b1;
            busy <= 1'b0;
          end else begin
            hold      <= mem[idx_nx[AW-1:0]];
            byte_done <= 1'b1;
          end
        end
      end else if (blk_wr) begin
        if (buffered) idx <= idx_inc;
        else begin
          idx  <= idx_eff;
          hold <= blk_wdata;
        end
      end else if (blk_rd) begin
        if (!buffered) begin
          idx <= idx_eff;
        end else if (!fin && idx_inc == count) begin
          idx  <= '0;
          fin  <= 1'b1;
          busy <= 1'b0;
        end else begin
          idx <= idx_inc;
        end
      end
    end
  end
endmodule

// File: rtl/smbus_blkbuf_chk.sv
module smbus_blkbuf_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          aux_wr,
  input logic [DW-1:0] aux_wdata,
  input logic [1:0]    aux_q,
  input logic          start,
  input logic          exec,
  input logic          sts_wr,
  input logic          busy,
  input logic          done,
  input logic          byte_done,
  input logic          dev_err,
  input logic          len_we,
  input logic          send_req
);
  a_r2_aux_kept: assert property (@(posedge clk) disable iff (!rst_n)
    aux_wr |=> aux_q == $past(aux_wdata[1:0]));

  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r4_send_done: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> done && !busy);

  a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && busy && dev_err && !start) |=> !send_req && !len_we);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_err && !sts_wr) |=> dev_err);

  a_r6_byte_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (len_we && busy) |-> byte_done);
endmodule

bind smbus_blkbuf smbus_blkbuf_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .aux_wr(aux_wr), .aux_wdata(aux_wdata),
  .aux_q(aux_q), .start(start), .exec(exec), .sts_wr(sts_wr),
  .busy(busy), .done(done), .byte_done(byte_done), .dev_err(dev_err),
  .len_we(len_we), .send_req(send_req)
);

// File: tb/smbus_blkbuf_tb_top.sv
`timescale 1ns/1ps
module smbus_blkbuf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aux_wr = 0, start = 0, exec = 0, is_read = 0, last_byte = 0;
  logic blk_wr = 0, blk_rd = 0, sts_wr = 0, eng_we = 0;
  logic [7:0] aux_wdata = 0, count = 0, rd_len = 0, blk_wdata = 0, eng_wdata = 0;
  logic [2:0] sts_wdata = 0;
  logic [4:0] eng_waddr = 0, eng_raddr = 0;
  logic [1:0] aux_q;
  logic [7:0] blk_rdata, len_q, eng_rdata;
  logic busy, done, byte_done, dev_err, len_we, send_req;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  smbus_blkbuf dut_i (
    .clk(clk), .rst_n(rst_n), .aux_wr(aux_wr), .aux_wdata(aux_wdata), .aux_q(aux_q),
    .start(start), .exec(exec), .is_read(is_read), .count(count),
    .last_byte(last_byte), .rd_len(rd_len), .blk_wr(blk_wr), .blk_wdata(blk_wdata),
    .blk_rd(blk_rd), .blk_rdata(blk_rdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .busy(busy), .done(done), .byte_done(byte_done), .dev_err(dev_err),
    .len_we(len_we), .len_q(len_q), .send_req(send_req), .eng_we(eng_we),
    .eng_waddr(eng_waddr), .eng_wdata(eng_wdata), .eng_raddr(eng_raddr),
    .eng_rdata(eng_rdata)
  );

  localparam int NV = 6;
  localparam logic [7:0] WTAB [NV] = '{8'h3C, 8'h00, 8'hFF, 8'h81, 8'h5E, 8'h17};

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic do_start(); start = 1; tick(); start = 0; endtask
  task automatic do_exec();  exec = 1;  tick(); exec = 0;  endtask
  task automatic do_bwr(input logic [7:0] d); blk_wdata = d; blk_wr = 1; tick(); blk_wr = 0; endtask
  task automatic do_brd(); blk_rd = 1; tick(); blk_rd = 0; endtask
  task automatic do_sts(input logic [2:0] m); sts_wdata = m; sts_wr = 1; tick(); sts_wr = 0; endtask
  task automatic do_aux(input logic [7:0] d); aux_wdata = d; aux_wr = 1; tick(); aux_wr = 0; endtask
  task automatic do_fill(input logic [4:0] a, input logic [7:0] d);
    eng_waddr = a; eng_wdata = d; eng_we = 1; tick(); eng_we = 0;
  endtask
  task automatic eng_chk(input string r, input logic [4:0] a, input logic [7:0] e);
    eng_raddr = a; #1; chk(r, eng_rdata, e);
  endtask

  task automatic summary();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 byte_done", byte_done, 0); chk("R1 dev_err", dev_err, 0);
    chk("R1 aux", aux_q, 0); chk("R1 blk_rdata", blk_rdata, 0);

    // R2 only two bits kept
    do_aux(8'hFD); chk("R2 aux", aux_q, 2'b01);
    do_aux(8'h02); chk("R2 aux buffered", aux_q, 2'b10);

    // R3/R4 buffered write from vector table
    do_start(); chk("R9 start busy", busy, 1);
    for (int i = 0; i < NV; i++) do_bwr(WTAB[i]);
    for (int i = 0; i < NV; i++) eng_chk("R3 stored byte", 5'(i), WTAB[i]);
    count = 8'(NV); is_read = 0;
    do_exec();
    chk("R4 send_req", send_req, 1); chk("R4 done", done, 1); chk("R4 busy", busy, 0);
    do_sts(3'b111); chk("R11 done cleared", done, 0);

    // R4 count mismatch
    do_start();
    do_bwr(8'h01); do_bwr(8'h02); do_bwr(8'h03);
    count = 5;
    do_exec();
    chk("R4 mismatch err", dev_err, 1); chk("R4 mismatch no send", send_req, 0);

    // R10 exec with error pending
    do_start(); is_read = 1; rd_len = 8'h09;
    do_exec();
    chk("R10 busy cleared", busy, 0); chk("R10 no len", len_we, 0);
    chk("R10 err kept", dev_err, 1);
    is_read = 0;
    do_sts(3'b100); chk("R11 err cleared", dev_err, 0);

    // R4 index reset after mismatch, R3 wrap
    do_bwr(8'hAB); eng_chk("R4 index reset", 0, 8'hAB);
    for (int i = 1; i < 32; i++) do_bwr(8'(i));
    do_bwr(8'h5A);
    eng_chk("R3 wrap to 0", 0, 8'h5A); eng_chk("R3 wrap keeps 1", 1, 8'h01);

    // R5 buffered read
    for (int i = 0; i < 4; i++) do_fill(5'(i), 8'hC0 + 8'(i));
    do_start(); is_read = 1; rd_len = 4;
    do_exec();
    chk("R5 len_we", len_we, 1); chk("R5 len_q", len_q, 4); chk("R5 done", done, 1);
    count = 4;
    for (int k = 0; k < 4; k++) begin
      chk("R5 read byte", blk_rdata, 8'hC0 + 8'(k));
      do_brd();
    end
    chk("R5 index back to 0", blk_rdata, 8'hC0);

    // R9 start while unfinished
    do_sts(3'b111);
    do_start(); do_exec();
    do_brd(); chk("R9 pre", blk_rdata, 8'hC1);
    do_start();
    chk("R9 index reset", blk_rdata, 8'hC0); chk("R9 busy", busy, 1);
    do_exec(); do_sts(3'b111);

    // R6/R7 byte-mode read
    do_aux(8'h00);
    do_fill(0, 8'h11); do_fill(1, 8'h22); do_fill(2, 8'h33);
    do_start(); rd_len = 3;
    do_exec();
    chk("R6 first byte", blk_rdata, 8'h11); chk("R6 busy", busy, 1);
    chk("R6 byte_done", byte_done, 1);
    last_byte = 0; do_sts(3'b010);
    chk("R7 next byte", blk_rdata, 8'h22); chk("R7 byte_done", byte_done, 1);
    chk("R7 busy held", busy, 1);
    last_byte = 1; do_sts(3'b011);
    chk("R7 last byte", blk_rdata, 8'h33); chk("R7 busy clear", busy, 0);
    chk("R11 set wins done", done, 1); chk("R11 byte_done cleared", byte_done, 0);
    last_byte = 0;

    // R8 byte-mode write
    do_sts(3'b111); is_read = 0; count = 3;
    do_bwr(8'hA1);
    chk("R8 holding", blk_rdata, 8'hA1);
    do_start(); do_exec();
    chk("R8 busy", busy, 1); chk("R8 byte_done", byte_done, 1);
    eng_chk("R8 byte0", 0, 8'hA1);
    do_bwr(8'hA2); do_sts(3'b010);
    eng_chk("R8 byte1", 1, 8'hA2); chk("R8 no send yet", send_req, 0);
    chk("R8 byte_done again", byte_done, 1);
    do_bwr(8'hA3); do_sts(3'b010);
    eng_chk("R8 byte2", 2, 8'hA3);
    do_sts(3'b010);
    chk("R8 send", send_req, 1); chk("R8 done", done, 1); chk("R8 busy clear", busy, 0);

    tick();
    summary();
  end
endmodule